// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Length Decode

This block fetches instructions one byte at a time from a byte-addressed memory with a 24-bit address space. It starts at the address held in its next-instruction register. The first byte it receives is the opcode, and the two most significant bits of that opcode give the instruction length. The block collects the remaining bytes into a 48-bit left-justified buffer and presents the finished instruction with a valid/ready handshake. After the last byte arrives, it steps the next-instruction address forward by the instruction length.

A redirect input, used for branches, replaces the next-instruction address and throws away any instruction that is partly assembled or waiting to be taken. If the memory still owes a byte when the redirect arrives, that byte is drained and ignored. Two conditions stop the block: fetching the all-zero opcode, and a redirect to an odd address. In either case it raises a sticky halt with a reason code and issues no further memory traffic until reset.

Top module: `insn_fetch_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, next_addr equals 0x000000, insn_valid and halted are low, halt_code is 00, and a request for address 0x000000 is pending on the memory port.
- R2: Opcode bits [7:6] give insn_len in bytes: 00 gives 2, 01 and 10 give 4, 11 gives 6.
- R3: insn_data holds the instruction left-justified. The opcode is in bits [47:40] and each later byte sits in the next lower byte lane. Lanes beyond the instruction length read as zero.
- R4: Bytes are requested one at a time at next_addr + 0, +1, and so on. At most one request is outstanding, so mem_req_valid stays low from the cycle after acceptance until the response arrives.
- R5: When an instruction is presented, insn_addr is its first byte's address and next_addr has already moved forward by insn_len, modulo 2^24 (0xFFFFFE with a 6-byte instruction gives 0x000004).
- R6: insn_valid stays high with stable insn_data and insn_addr until insn_ready is seen. No memory request is made during that time.
- R7: A fetched opcode of 0x00 sets halted with halt_code 01. next_addr keeps the address of the illegal instruction and no instruction is presented.
- R8: A redirect with an even address loads it into next_addr and discards any partial or presented instruction. Any response still owed is drained unused, and the next instruction presented starts at the redirect address.
- R9: A redirect with an odd address loads it into next_addr and sets halted with halt_code 10.
- R10: Once halted, the block stays halted until reset. It makes no memory request, presents no instruction and ignores redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Load a new fetch address this cycle |
| redir_addr | input | 24 | New fetch address |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_addr | output | 24 | Address of requested byte |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Requested byte is returned |
| mem_rsp_data | input | 8 | Returned byte |
| insn_valid | output | 1 | A complete instruction is presented |
| insn_data | output | 48 | Left-justified instruction bytes |
| insn_len | output | 3 | Instruction length in bytes |
| insn_addr | output | 24 | Address of the instruction's opcode |
| insn_ready | input | 1 | Consumer takes the instruction |
| next_addr | output | 24 | Next-instruction address |
| halted | output | 1 | Sticky halt |
| halt_code | output | 2 | Halt reason: 01 illegal opcode, 10 odd address |

## Verification
A wrong byte index or a stale lane shows up in insn_data on the very first instruction it affects, as a misplaced or nonzero low byte. A wrong length decode shows up as a mismatch in insn_len and next_addr in the same cycle that insn_valid rises, and every later instruction then decodes from the wrong address. A state machine that mishandles an owed response after a redirect delivers a byte from the old stream into the first instruction at the new address. A faulty halt path shows up within a cycle as renewed memory requests or a changed next_addr.

// File: rtl/ifu_pkg.sv
`timescale 1ns/1ps
package ifu_pkg;
   typedef enum logic [2:0] {
      ST_REQ   = 3'd0,
      ST_WAIT  = 3'd1,
      ST_FLUSH = 3'd2,
      ST_SHOW  = 3'd3,
      ST_HALT  = 3'd4
   } fetch_state_e;

   typedef enum logic [1:0] {
      HALT_NONE    = 2'd0,
      HALT_ILLEGAL = 2'd1,
      HALT_ODD     = 2'd2
   } halt_code_e;
endpackage

// File: rtl/ifu_len_decode.sv
`timescale 1ns/1ps
module ifu_len_decode #(
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 3,
   parameter int LEN_SHORT = 2,
   parameter int LEN_MID   = 4,
   parameter int LEN_LONG  = 6,
   parameter logic [BYTE_W-1:0] ILLEGAL_OP = '0
) (
   input  logic [BYTE_W-1:0] opcode,
   output logic [CNT_W-1:0]  len_bytes,
   output logic              illegal
);
   logic [1:0] fmt_class;
   assign fmt_class = opcode[BYTE_W-1 -: 2];

   // length class sits in the two top opcode bits
   always_comb begin
      unique case (fmt_class)
         2'b00:   len_bytes = CNT_W'(LEN_SHORT);
         2'b11:   len_bytes = CNT_W'(LEN_LONG);
         default: len_bytes = CNT_W'(LEN_MID);
      endcase
   end

   assign illegal = (opcode == ILLEGAL_OP);
endmodule

// File: rtl/ifu_byte_gather.sv
`timescale 1ns/1ps
module ifu_byte_gather #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 6,
   parameter int CNT_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap_en,
   input  logic [CNT_W-1:0]            cap_idx,
   input  logic [BYTE_W-1:0]           cap_byte,
   output logic [MAX_BYTES*BYTE_W-1:0] buf_out
);
   for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      if (k == 0) begin : g_opcode_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          lane_q <= '0;
            else if (cap_en && cap_idx == '0)    lane_q <= cap_byte;
         end
      end else begin : g_tail_lane
         // tail lanes are wiped when a new opcode lands
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 lane_q <= '0;
            else if (cap_en && cap_idx == CNT_W'(k))    lane_q <= cap_byte;
            else if (cap_en && cap_idx == '0)           lane_q <= '0;
         end
      end
      assign buf_out[(MAX_BYTES-1-k)*BYTE_W +: BYTE_W] = lane_q;
   end

   assert_lane_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> (cap_idx < CNT_W'(MAX_BYTES)));
endmodule

// File: rtl/ifu_addr_reg.sv
`timescale 1ns/1ps
module ifu_addr_reg #(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 3,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              adv,
   input  logic [CNT_W-1:0]  adv_len,
   output logic [ADDR_W-1:0] pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= RESET_ADDR;
      else if (load) pc <= load_val;
      else if (adv)  pc <= pc + ADDR_W'(adv_len);
   end
endmodule

// File: rtl/insn_fetch_unit.sv
`timescale 1ns/1ps
module insn_fetch_unit #(
   parameter int ADDR_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 6,
   parameter int LEN_SHORT = 2,
   parameter int LEN_MID   = 4,
   parameter int LEN_LONG  = 6,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   parameter logic [BYTE_W-1:0] ILLEGAL_OP = '0
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 redir_valid,
   input  logic [ADDR_W-1:0]                    redir_addr,
   output logic                                 mem_req_valid,
   output logic [ADDR_W-1:0]                    mem_req_addr,
   input  logic                                 mem_req_ready,
   input  logic                                 mem_rsp_valid,
   input  logic [BYTE_W-1:0]                    mem_rsp_data,
   output logic                                 insn_valid,
   output logic [MAX_BYTES*BYTE_W-1:0]          insn_data,
   output logic [$clog2(MAX_BYTES+1)-1:0]       insn_len,
   output logic [ADDR_W-1:0]                    insn_addr,
   input  logic                                 insn_ready,
   output logic [ADDR_W-1:0]                    next_addr,
   output logic                                 halted,
   output logic [1:0]                           halt_code
);
   import ifu_pkg::*;

   localparam int CNT_W = $clog2(MAX_BYTES + 1);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must hold a two-bit length class");
   end
   if (LEN_SHORT < 2 || LEN_SHORT > LEN_MID || LEN_MID > LEN_LONG || LEN_LONG > MAX_BYTES) begin : g_bad_len
      $error("length classes must be ordered and fit the buffer");
   end
   if ((LEN_SHORT % 2) != 0 || (LEN_MID % 2) != 0 || (LEN_LONG % 2) != 0) begin : g_odd_len
      $error("every instruction length must be even");
   end
   if (RESET_ADDR[0]) begin : g_odd_reset
      $error("reset fetch address must be even");
   end

   fetch_state_e      state_q, state_d;
   halt_code_e        halt_q, halt_d;
   logic [CNT_W-1:0]  idx_q, idx_d, len_q, len_d, dec_len;
   logic [ADDR_W-1:0] start_q, start_d, pc;
   logic              pc_load, pc_adv, cap_en, dec_illegal, redir_take;

   ifu_len_decode #(
      .BYTE_W(BYTE_W), .CNT_W(CNT_W), .LEN_SHORT(LEN_SHORT),
      .LEN_MID(LEN_MID), .LEN_LONG(LEN_LONG), .ILLEGAL_OP(ILLEGAL_OP)
   ) u_dec (
      .opcode(mem_rsp_data), .len_bytes(dec_len), .illegal(dec_illegal)
   );

   ifu_byte_gather #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_gather (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(idx_q),
      .cap_byte(mem_rsp_data), .buf_out(insn_data)
   );

   ifu_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)) u_pc (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .load_val(redir_addr),
      .adv(pc_adv), .adv_len(len_q), .pc(pc)
   );

   assign redir_take = redir_valid && (state_q != ST_HALT);

   always_comb begin
      state_d = state_q;
      halt_d  = halt_q;
      idx_d   = idx_q;
      len_d   = len_q;
      start_d = start_q;
      pc_load = 1'b0;
      pc_adv  = 1'b0;
      cap_en  = 1'b0;
      if (redir_take) begin
         pc_load = 1'b1;
         idx_d   = '0;
         if (redir_addr[0]) begin
            state_d = ST_HALT;
            halt_d  = HALT_ODD;
         end else begin
            unique case (state_q)
               ST_REQ:           state_d = mem_req_ready ? ST_FLUSH : ST_REQ;
               ST_WAIT, ST_FLUSH: state_d = mem_rsp_valid ? ST_REQ : ST_FLUSH;
               default:          state_d = ST_REQ;
            endcase
         end
      end else begin
         unique case (state_q)
            ST_REQ: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) begin
               cap_en = 1'b1;
               if (idx_q == '0) begin
                  if (dec_illegal) begin
                     state_d = ST_HALT;
                     halt_d  = HALT_ILLEGAL;
                  end else begin
                     len_d   = dec_len;
                     start_d = pc;
                     idx_d   = CNT_W'(1);
                     state_d = ST_REQ;
                  end
               end else if (idx_q + CNT_W'(1) == len_q) begin
                  pc_adv  = 1'b1;
                  state_d = ST_SHOW;
               end else begin
                  idx_d   = idx_q + CNT_W'(1);
                  state_d = ST_REQ;
               end
            end
            ST_FLUSH: if (mem_rsp_valid) state_d = ST_REQ;
            ST_SHOW: if (insn_ready) begin
               idx_d   = '0;
               state_d = ST_REQ;
            end
            default: state_d = ST_HALT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_REQ;
         halt_q  <= HALT_NONE;
         idx_q   <= '0;
         len_q   <= '0;
         start_q <= '0;
      end else begin
         state_q <= state_d;
         halt_q  <= halt_d;
         idx_q   <= idx_d;
         len_q   <= len_d;
         start_q <= start_d;
      end
   end

   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = pc + ADDR_W'(idx_q);
   assign insn_valid    = (state_q == ST_SHOW);
   assign insn_len      = len_q;
   assign insn_addr     = start_q;
   assign next_addr     = pc;
   assign halted        = (state_q == ST_HALT);
   assign halt_code     = halt_q;

   assert_one_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   assert_hold_instruction_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !insn_ready && !redir_valid) |=>
         (insn_valid && $stable(insn_data) && $stable(insn_addr)));

   assert_quiet_while_presenting_R6: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |-> !mem_req_valid);

   assert_even_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |-> (!insn_len[0] && insn_len != '0));

   assert_no_illegal_shown_R7: assert property (@(posedge clk) disable iff (!rst_n)
      insn_valid |-> (insn_data[MAX_BYTES*BYTE_W-1 -: BYTE_W] != ILLEGAL_OP));

   assert_even_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !halted |-> !next_addr[0]);

   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(halt_code) && $stable(next_addr)));

   assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_req_valid && !insn_valid && halt_code != 2'b00));
endmodule

// File: tb/test_insn_fetch_unit.sv
`timescale 1ns/1ps
module test_insn_fetch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redir_valid = 1'b0;
   logic [23:0] redir_addr = '0;
   logic        mem_req_valid;
   logic [23:0] mem_req_addr;
   logic        mem_req_ready;
   logic        mem_rsp_valid;
   logic [7:0]  mem_rsp_data;
   logic        insn_valid;
   logic [47:0] insn_data;
   logic [2:0]  insn_len;
   logic [23:0] insn_addr;
   logic        insn_ready = 1'b0;
   logic [23:0] next_addr;
   logic        halted;
   logic [1:0]  halt_code;

   int checks = 0;
   int errors = 0;
   int overlap = 0;
   logic [23:0] exp_pc;
   logic [7:0] mem [int unsigned];

   always #10 clk = ~clk;

   insn_fetch_unit i_insn_fetch_unit (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .insn_valid(insn_valid), .insn_data(insn_data), .insn_len(insn_len), .insn_addr(insn_addr),
      .insn_ready(insn_ready), .next_addr(next_addr), .halted(halted), .halt_code(halt_code)
   );

   function automatic logic [7:0] mem_byte(logic [23:0] a);
      logic [31:0] h;
      logic [7:0]  b;
      if (mem.exists(int'(a))) return mem[int'(a)];
      h = {8'h00, a} * 32'h9E3779B1;
      b = h[23:16];
      if (b == 8'h00) b = 8'h5A;
      return b;
   endfunction

   function automatic int len_of(logic [7:0] op);
      case (op[7:6])
         2'b00:   return 2;
         2'b11:   return 6;
         default: return 4;
      endcase
   endfunction

   function automatic logic [47:0] exp_word(logic [23:0] a);
      logic [47:0] w = '0;
      int n = len_of(mem_byte(a));
      for (int i = 0; i < n; i++) w[47-8*i -: 8] = mem_byte(a + 24'(i));
      return w;
   endfunction

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // memory: one byte per request, 0..2 cycles of latency
   initial begin
      bit busy = 1'b0;
      int lat = 0;
      logic [23:0] pend = '0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (!rst_n) begin
            busy = 1'b0;
            mem_req_ready = 1'b0;
         end else begin
            if (busy) begin
               if (lat == 0) begin
                  mem_rsp_valid = 1'b1;
                  mem_rsp_data  = mem_byte(pend);
                  busy = 1'b0;
               end else lat--;
            end
            if (busy && mem_req_valid) overlap++;
            mem_req_ready = !busy && ($urandom % 4 != 0);
            #1;
            if (mem_req_valid && mem_req_ready) begin
               busy = 1'b1;
               pend = mem_req_addr;
               lat  = $urandom % 3;
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic do_reset();
      rst_n = 1'b0;
      redir_valid = 1'b0;
      insn_ready = 1'b0;
      repeat (3) @(negedge clk);
      #3 rst_n = 1'b1;
      exp_pc = 24'h000000;
   endtask

   task automatic redirect(input logic [23:0] a);
      @(negedge clk);
      redir_valid = 1'b1;
      redir_addr  = a;
      @(negedge clk);
      redir_valid = 1'b0;
      exp_pc = a;
   endtask

   task automatic take_insn(input int hold, input string tag);
      logic [7:0]  op = mem_byte(exp_pc);
      int          n = len_of(op);
      logic [47:0] w = exp_word(exp_pc);
      int          waited = 0;
      while (!insn_valid && waited < 300) begin
         @(negedge clk);
         waited++;
      end
      chk(insn_valid, {tag, " R6 instruction presented"}, 64'(insn_valid), 1);
      chk(insn_len == 3'(n), {tag, " R2 length from opcode class"}, 64'(insn_len), 64'(n));
      chk(insn_data == w, {tag, " R3 left-justified data"}, 64'(insn_data), 64'(w));
      chk(insn_addr == exp_pc, {tag, " R5 instruction address"}, 64'(insn_addr), 64'(exp_pc));
      chk(next_addr == exp_pc + 24'(n), {tag, " R5 next address advanced"}, 64'(next_addr), 64'(exp_pc + 24'(n)));
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(insn_valid && insn_data == w && insn_addr == exp_pc && !mem_req_valid,
             {tag, " R6 held stable without requests"}, {insn_valid, mem_req_valid, 14'(0), insn_data}, {2'b10, 14'(0), w});
      end
      insn_ready = 1'b1;
      @(negedge clk);
      insn_ready = 1'b0;
      exp_pc = exp_pc + 24'(n);
   endtask

   initial begin
      void'($urandom(32'd2024));
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(next_addr == 24'h0 && !insn_valid && !halted && halt_code == 2'b00,
          "R1 reset outputs", {next_addr, 3'b0, insn_valid, halted, halt_code}, 0);
      chk(mem_req_valid && mem_req_addr == 24'h0, "R1 R4 first request at reset address",
          {mem_req_valid, mem_req_addr}, {1'b1, 24'h0});

      // random sequential stream
      for (int i = 0; i < 30; i++) take_insn($urandom % 4, "seq");

      // directed: one opcode of each class
      mem[32'h1000] = 8'h12; mem[32'h1001] = 8'hAB;
      mem[32'h1002] = 8'h45; mem[32'h1003] = 8'h00; mem[32'h1004] = 8'h7E; mem[32'h1005] = 8'h01;
      mem[32'h1006] = 8'h8A; mem[32'h1007] = 8'h11; mem[32'h1008] = 8'h22; mem[32'h1009] = 8'h33;
      mem[32'h100A] = 8'hF0;
      redirect(24'h001000);
      take_insn(0, "R8 R2 class00");
      take_insn(1, "R2 class01");
      take_insn(6, "R2 R6 class10 long hold");
      take_insn(2, "R2 class11");

      // redirect while a fetch is in flight
      for (int r = 0; r < 12; r++) begin
         repeat ($urandom % 5) @(negedge clk);
         redirect(24'($urandom) & 24'h3FFFFE);
         for (int j = 0; j < 3; j++) take_insn($urandom % 3, "R8 after redirect");
      end

      // wrap of the address space with a 6-byte instruction
      mem[32'hFFFFFE] = 8'hC3;
      redirect(24'hFFFFFE);
      take_insn(1, "R5 wrap");
      chk(exp_pc == 24'h000004, "R5 wrapped next address", 64'(exp_pc), 64'h4);
      take_insn(0, "R5 after wrap");

      // odd redirect halts
      redirect(24'h002345);
      chk(halted && halt_code == 2'b10, "R9 odd redirect halt", {halted, halt_code}, {1'b1, 2'b10});
      chk(next_addr == 24'h002345, "R9 rejected target shown", 64'(next_addr), 64'h2345);
      begin
         int busy_cnt = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req_valid || insn_valid || !halted) busy_cnt++;
         end
         chk(busy_cnt == 0, "R10 silent while halted", 64'(busy_cnt), 0);
      end
      redirect(24'h004000);
      chk(halted && next_addr == 24'h002345 && halt_code == 2'b10, "R10 redirect ignored while halted",
          {halted, halt_code, next_addr}, {1'b1, 2'b10, 24'h002345});

      // illegal opcode halts
      do_reset();
      mem[32'h800000] = 8'h00;
      redirect(24'h800000);
      begin
         int waited = 0;
         int busy_cnt = 0;
         while (!halted && waited < 100) begin
            chk(!insn_valid, "R7 no instruction before illegal halt", 64'(insn_valid), 0);
            @(negedge clk);
            waited++;
         end
         chk(halted && halt_code == 2'b01, "R7 illegal opcode halt", {halted, halt_code}, {1'b1, 2'b01});
         chk(next_addr == 24'h800000, "R7 address not advanced", 64'(next_addr), 64'h800000);
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req_valid || insn_valid) busy_cnt++;
         end
         chk(busy_cnt == 0, "R7 no traffic after illegal halt", 64'(busy_cnt), 0);
      end
      redirect(24'h000100);
      chk(halted && next_addr == 24'h800000, "R10 sticky after illegal opcode", {halted, next_addr}, {1'b1, 24'h800000});

      // reset recovers
      do_reset();
      @(negedge clk);
      chk(!halted && next_addr == 24'h0, "R1 reset clears halt", {halted, next_addr}, 0);
      take_insn(0, "R1 fetch after reset");

      chk(overlap == 0, "R4 single outstanding request", 64'(overlap), 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule